// File: doc/BRIEF.md
# Block-Transfer Write-Through Cache Controller

This block is a small direct-mapped cache placed between a processor's word-addressed load/store port and a backing memory. The memory only moves whole four-word blocks in either direction and signals completion with a ready handshake, so its latency can change from one transfer to the next. Reads that hit return data in the cycle of the request. Read misses fetch the containing block, fill the line and then answer.

Every write reaches memory. A write hit updates the cached word and pushes the whole updated line out. The memory cannot take a single word, so a write miss reads the containing block, merges the new word into it and writes the block back, and leaves the cache untouched.

A parameter turns the block into a pass-through. In that mode it forwards every access to memory through the same handshake, with no lookup and no counting. Two counters record lookups that hit and lookups that miss.

Top module: `wtc_cache`

## Requirements
- R1: After reset `cpu_busy`, `cpu_done`, `mem_rd` and `mem_wr` are 0, both counters are 0 and every line is invalid, so the first read of any address misses.
- R2: A read whose line is valid with a matching tag raises `cpu_done` with the correct word on `cpu_rdata` in the same cycle as the request. It drives no memory strobe and adds one to `hit_count` at the next clock edge.
- R3: A read miss issues a block read at block address `cpu_addr[7:2]` and fills the line with its tag. It raises `cpu_done` with the requested word one cycle after the cycle in which `mem_ready` was high, and adds one to `miss_count`. Later reads of any word of that block hit.
- R4: A write hit updates the cached word. It then writes the full line, with the new word at its offset and the other three words unchanged, to the same block address. It raises `cpu_done` one cycle after `mem_ready` and adds one to `hit_count`.
- R5: A write miss reads the block, replaces the addressed word, writes the merged block back and adds one to `miss_count`. It allocates nothing, so the line previously held at that index still hits and a read of the written address misses.
- R6: A memory strobe stays high while `mem_ready` is low and is low in the cycle after `mem_ready` was seen high.
- R7: Requests presented while `cpu_busy` is high are ignored: they reach neither memory nor the counters.
- R8: Word k of a block travels in bits [32k+31:32k] of `mem_rdata`/`mem_wdata`. The line index is `cpu_addr[3:2]` and the tag is `cpu_addr[7:4]`. Two addresses with equal index and different tags evict each other.
- R9: With `BYPASS`=1 every read goes to memory and every write does a block read, merge and block write. Data is returned as in R3, and both counters stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Read request, sampled when not busy; wins over a write |
| cpu_wr | input | 1 | Write request, sampled when not busy |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` |
| cpu_busy | output | 1 | Controller is working on an accepted request |
| cpu_done | output | 1 | Request complete |
| mem_rd | output | 1 | Block read strobe |
| mem_wr | output | 1 | Block write strobe |
| mem_addr | output | ADDR_W-OFF_W | Block address |
| mem_wdata | output | BLK_WORDS*DATA_W | Block written to memory |
| mem_rdata | input | BLK_WORDS*DATA_W | Block returned by memory, valid with `mem_ready` |
| mem_ready | input | 1 | Memory finished the current transfer |
| hit_count | output | CNT_W | Lookups that hit, saturating |
| miss_count | output | CNT_W | Lookups that missed, saturating |

## Verification
A read hit is due in the same cycle as the request, so the bench drives the request at a falling edge and samples `cpu_done` and `cpu_rdata` a fraction of a cycle later. Every other result is due exactly one cycle after the cycle in which `mem_ready` was high. The bench therefore records `mem_ready` at each falling edge and, when `cpu_done` shows up, checks that the previous sample had ready set. The memory model picks a new random latency for every transfer, so this timing is checked at many different latencies. Counters move at the clock edge that accepts the request and are read at the falling edge after completion. Memory contents are compared with a reference image when each write completes.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_PUSH  = 2'd2,
      ST_RESP  = 2'd3
   } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int LINES = 4,
   parameter int TAG_W = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag
);
   logic [LINES-1:0] valid;
   logic [TAG_W-1:0] tags [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n)       valid <= '0;
      else if (fill_en) valid[fill_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_en) tags[fill_idx] <= fill_tag;
   end

   assign lk_hit = valid[lk_idx] && (tags[lk_idx] == lk_tag);

   // a fill must leave its line valid for later lookups
   assert_fill_marks_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> valid[$past(fill_idx)]);
endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
   parameter int LINES  = 4,
   parameter int LINE_W = 128,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line
);
   logic [LINE_W-1:0] lines [LINES];

   always_ff @(posedge clk) begin
      if (wr_en) lines[wr_idx] <= wr_line;
   end

   assign rd_line = lines[rd_idx];
endmodule

// File: rtl/wtc_counter.sv
module wtc_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)                   count <= '0;
      else if (inc && count != '1)  count <= count + 1'b1;
   end

   assert_count_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int LINES     = 4,
   parameter int CNT_W     = 16,
   parameter bit BYPASS    = 1'b0,
   localparam int OFF_W    = $clog2(BLK_WORDS),
   localparam int IDX_W    = $clog2(LINES),
   localparam int TAG_W    = ADDR_W - OFF_W - IDX_W,
   localparam int BADDR_W  = ADDR_W - OFF_W,
   localparam int LINE_W   = BLK_WORDS * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_rd,
   input  logic               cpu_wr,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               cpu_busy,
   output logic               cpu_done,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic [BADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0]  mem_wdata,
   input  logic [LINE_W-1:0]  mem_rdata,
   input  logic               mem_ready,
   output logic [CNT_W-1:0]   hit_count,
   output logic [CNT_W-1:0]   miss_count
);
   import wtc_pkg::*;

   localparam bit USE_CACHE = !BYPASS;

   if ((1 << OFF_W) != BLK_WORDS || BLK_WORDS < 2) begin : g_bad_blk
      $error("BLK_WORDS must be a power of two and at least 2");
   end
   if ((1 << IDX_W) != LINES || LINES < 2) begin : g_bad_lines
      $error("LINES must be a power of two and at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits");
   end

   function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0]  off,
                                                  input logic [DATA_W-1:0] w);
      logic [LINE_W-1:0] r;
      r = line;
      r[off*DATA_W +: DATA_W] = w;
      return r;
   endfunction

   function automatic logic [DATA_W-1:0] get_word(input logic [LINE_W-1:0] line,
                                                  input logic [OFF_W-1:0]  off);
      return line[off*DATA_W +: DATA_W];
   endfunction

   wtc_state_e        state;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata;
   logic              req_wr;
   logic [LINE_W-1:0] buf_line;

   logic [OFF_W-1:0]  cpu_off, req_off;
   logic [IDX_W-1:0]  cpu_idx, req_idx;
   logic [TAG_W-1:0]  cpu_tag, req_tag;
   assign cpu_off = cpu_addr[OFF_W-1:0];
   assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
   assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
   assign req_off = req_addr[OFF_W-1:0];
   assign req_idx = req_addr[OFF_W +: IDX_W];
   assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

   logic              lk_hit;
   logic [LINE_W-1:0] lk_line;
   logic              is_idle, take_rd, take_wr;
   logic              rd_hit, wr_hit, miss_go, fill_en;
   logic              line_we;
   logic [IDX_W-1:0]  line_widx;
   logic [LINE_W-1:0] line_wdata, hit_merged;

   assign is_idle    = (state == ST_IDLE);
   assign take_rd    = is_idle && cpu_rd;
   assign take_wr    = is_idle && !cpu_rd && cpu_wr;
   assign rd_hit     = take_rd && lk_hit;
   assign wr_hit     = take_wr && lk_hit;
   assign miss_go    = (take_rd || take_wr) && !lk_hit;
   assign fill_en    = USE_CACHE && (state == ST_FETCH) && mem_ready && !req_wr;
   assign hit_merged = put_word(lk_line, cpu_off, cpu_wdata);
   assign line_we    = wr_hit || fill_en;
   assign line_widx  = wr_hit ? cpu_idx : req_idx;
   assign line_wdata = wr_hit ? hit_merged : mem_rdata;

   if (BYPASS) begin : g_bypass
      assign lk_hit  = 1'b0;
      assign lk_line = '0;
   end else begin : g_cached
      wtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
         .clk      (clk),
         .rst_n    (rst_n),
         .lk_idx   (cpu_idx),
         .lk_tag   (cpu_tag),
         .lk_hit   (lk_hit),
         .fill_en  (fill_en),
         .fill_idx (req_idx),
         .fill_tag (req_tag)
      );
      wtc_line_store #(.LINES(LINES), .LINE_W(LINE_W)) u_lines (
         .clk     (clk),
         .rd_idx  (cpu_idx),
         .rd_line (lk_line),
         .wr_en   (line_we),
         .wr_idx  (line_widx),
         .wr_line (line_wdata)
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         req_addr  <= '0;
         req_wdata <= '0;
         req_wr    <= 1'b0;
         buf_line  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (take_rd || take_wr) begin
                  req_addr  <= cpu_addr;
                  req_wdata <= cpu_wdata;
                  req_wr    <= take_wr;
               end
               if (wr_hit) begin
                  buf_line <= hit_merged;
                  state    <= ST_PUSH;
               end else if (miss_go) begin
                  state <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ready) begin
                  if (req_wr) begin
                     buf_line <= put_word(mem_rdata, req_off, req_wdata);
                     state    <= ST_PUSH;
                  end else begin
                     buf_line <= mem_rdata;
                     state    <= ST_RESP;
                  end
               end
            end
            ST_PUSH: begin
               if (mem_ready) state <= ST_RESP;
            end
            ST_RESP: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_rd    = (state == ST_FETCH);
   assign mem_wr    = (state == ST_PUSH);
   assign mem_addr  = req_addr[ADDR_W-1:OFF_W];
   assign mem_wdata = buf_line;
   assign cpu_busy  = !is_idle;
   assign cpu_done  = rd_hit || (state == ST_RESP);
   assign cpu_rdata = is_idle ? get_word(lk_line, cpu_off) : get_word(buf_line, req_off);

   wtc_counter #(.W(CNT_W)) u_hits (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (USE_CACHE && (rd_hit || wr_hit)),
      .count (hit_count)
   );
   wtc_counter #(.W(CNT_W)) u_misses (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (USE_CACHE && miss_go),
      .count (miss_count)
   );

   assert_rd_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && !mem_ready |=> mem_rd);
   assert_rd_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && mem_ready |=> !mem_rd);
   assert_wr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr && !mem_ready |=> mem_wr);
   assert_wr_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr && mem_ready |=> !mem_wr);
   assert_done_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done && cpu_busy |-> $past(mem_ready));
   assert_busy_addr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_busy && !cpu_done |=> $stable(mem_addr));
   assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   if (BYPASS) begin : g_bypass_chk
      assert_bypass_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
         hit_count == '0 && miss_count == '0);
   end
endmodule

// File: tb/tb_wtc_cache.sv
`timescale 1ns/100ps

module tb_wtc_mem #(
   parameter int BA_W = 6,
   parameter int LW   = 128
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd,
   input  logic            wr,
   input  logic [BA_W-1:0] addr,
   input  logic [LW-1:0]   wdata,
   output logic [LW-1:0]   rdata,
   output logic            ready
);
   logic [LW-1:0] store [1 << BA_W];
   int unsigned   cnt;

   function automatic logic [31:0] seed_word(input int a);
      return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ready <= 1'b0;
         cnt   <= 1;
         rdata <= '0;
         for (int b = 0; b < (1 << BA_W); b++)
            for (int w = 0; w < LW/32; w++)
               store[b][w*32 +: 32] <= seed_word(b*(LW/32) + w);
      end else if (ready) begin
         ready <= 1'b0;
         cnt   <= $urandom_range(3, 0);
      end else if (rd || wr) begin
         if (cnt == 0) begin
            ready <= 1'b1;
            rdata <= store[addr];
            if (wr) store[addr] <= wdata;
         end else begin
            cnt <= cnt - 1;
         end
      end
   end
endmodule

module tb_wtc_cache;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int LW = 128;
   localparam int BW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          sel = 1'b0;
   logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;

   logic [DW-1:0] a_rdata, b_rdata;
   logic a_busy, a_done, a_mrd, a_mwr, a_rdy;
   logic b_busy, b_done, b_mrd, b_mwr, b_rdy;
   logic [BW-1:0] a_maddr, b_maddr;
   logic [LW-1:0] a_mw, a_mr, b_mw, b_mr;
   logic [15:0] a_hits, a_miss, b_hits, b_miss;

   wtc_cache dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_rd(cpu_rd && !sel), .cpu_wr(cpu_wr && !sel),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(a_rdata),
      .cpu_busy(a_busy), .cpu_done(a_done),
      .mem_rd(a_mrd), .mem_wr(a_mwr), .mem_addr(a_maddr),
      .mem_wdata(a_mw), .mem_rdata(a_mr), .mem_ready(a_rdy),
      .hit_count(a_hits), .miss_count(a_miss)
   );
   tb_wtc_mem m0 (.clk(clk), .rst_n(rst_n), .rd(a_mrd), .wr(a_mwr), .addr(a_maddr),
                  .wdata(a_mw), .rdata(a_mr), .ready(a_rdy));

   wtc_cache #(.BYPASS(1'b1)) dut_bp (
      .clk(clk), .rst_n(rst_n),
      .cpu_rd(cpu_rd && sel), .cpu_wr(cpu_wr && sel),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(b_rdata),
      .cpu_busy(b_busy), .cpu_done(b_done),
      .mem_rd(b_mrd), .mem_wr(b_mwr), .mem_addr(b_maddr),
      .mem_wdata(b_mw), .mem_rdata(b_mr), .mem_ready(b_rdy),
      .hit_count(b_hits), .miss_count(b_miss)
   );
   tb_wtc_mem m1 (.clk(clk), .rst_n(rst_n), .rd(b_mrd), .wr(b_mwr), .addr(b_maddr),
                  .wdata(b_mw), .rdata(b_mr), .ready(b_rdy));

   wire          o_done  = sel ? b_done  : a_done;
   wire          o_busy  = sel ? b_busy  : a_busy;
   wire [DW-1:0] o_rdata = sel ? b_rdata : a_rdata;
   wire          o_rdy   = sel ? b_rdy   : a_rdy;
   wire [15:0]   o_hits  = sel ? b_hits  : a_hits;
   wire [15:0]   o_miss  = sel ? b_miss  : a_miss;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   logic [DW-1:0] ref_a [256];
   logic [DW-1:0] ref_b [256];
   bit            rv [4];
   logic [3:0]    rt [4];

   function automatic logic [31:0] seed_word(input int a);
      return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   function automatic bit model_hit(input logic [AW-1:0] a);
      return !sel && rv[a[3:2]] && (rt[a[3:2]] == a[7:4]);
   endfunction

   function automatic logic [LW-1:0] ref_block(input logic [AW-1:0] a);
      logic [LW-1:0] r;
      for (int w = 0; w < 4; w++)
         r[w*32 +: 32] = sel ? ref_b[{a[7:2], 2'(w)}] : ref_a[{a[7:2], 2'(w)}];
      return r;
   endfunction

   task automatic check(input bit ok, input string what, input logic [LW-1:0] act,
                        input logic [LW-1:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   // R6 monitor: strobe held until ready, dropped the cycle after
   logic pa_rd = 0, pa_wr = 0, pa_rdy = 0, pb_rd = 0, pb_wr = 0, pb_rdy = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pa_rd) check(a_mrd == !pa_rdy, "R6 read strobe (cached)", a_mrd, !pa_rdy);
         if (pa_wr) check(a_mwr == !pa_rdy, "R6 write strobe (cached)", a_mwr, !pa_rdy);
         if (pb_rd) check(b_mrd == !pb_rdy, "R6 read strobe (bypass)", b_mrd, !pb_rdy);
         if (pb_wr) check(b_mwr == !pb_rdy, "R6 write strobe (bypass)", b_mwr, !pb_rdy);
      end
      pa_rd = a_mrd; pa_wr = a_mwr; pa_rdy = a_rdy;
      pb_rd = b_mrd; pb_wr = b_mwr; pb_rdy = b_rdy;
   end

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input bit inj, input logic [AW-1:0] inj_a);
      bit exp_hit, last_rdy, imm;
      logic [15:0] h0, m0c;
      string rq;
      int cyc;
      exp_hit = model_hit(a);
      rq = sel ? "R9" : (wr ? (exp_hit ? "R4" : "R5") : (exp_hit ? "R2" : "R3"));
      h0 = o_hits; m0c = o_miss;
      @(negedge clk);
      cpu_rd = !wr; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
      #0.5;
      imm = o_done && !o_busy;
      check(imm == (exp_hit && !wr), {rq, " same-cycle completion only for read hit"}, imm, exp_hit && !wr);
      if (!imm) begin
         last_rdy = 1'b0;
         cyc = 0;
         forever begin
            @(negedge clk);
            if (inj) begin
               cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_addr = inj_a; cpu_wdata = 32'hBAD0BAD0;
            end else begin
               cpu_rd = 1'b0; cpu_wr = 1'b0;
            end
            #0.5;
            if (o_done) break;
            last_rdy = o_rdy;
            cyc++;
            if (cyc > 64) begin
               check(1'b0, {rq, " completion timeout"}, cyc, 64);
               break;
            end
         end
         check(last_rdy, {rq, " done one cycle after mem ready"}, last_rdy, 1);
      end
      if (!wr) begin
         check(o_rdata == (sel ? ref_b[a] : ref_a[a]), {rq, " read data"}, o_rdata,
               sel ? ref_b[a] : ref_a[a]);
      end
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
      #0.5;
      if (wr) begin
         if (sel) ref_b[a] = wd; else ref_a[a] = wd;
         check((sel ? m1.store[a[7:2]] : m0.store[a[7:2]]) == ref_block(a),
               {rq, " memory block after write"},
               sel ? m1.store[a[7:2]] : m0.store[a[7:2]], ref_block(a));
      end else if (!exp_hit && !sel) begin
         rv[a[3:2]] = 1'b1;
         rt[a[3:2]] = a[7:4];
      end
      if (sel) begin
         check(o_hits == 0 && o_miss == 0, "R9 counters stay zero", {o_hits, o_miss}, 0);
      end else begin
         check(o_hits == h0 + 16'(exp_hit) && o_miss == m0c + 16'(!exp_hit),
               {rq, " hit/miss counters"}, {o_hits, o_miss},
               {h0 + 16'(exp_hit), m0c + 16'(!exp_hit)});
      end
   endtask

   initial begin
      logic [15:0] mbase;
      void'($urandom(32'd2024));
      for (int i = 0; i < 256; i++) begin
         ref_a[i] = seed_word(i);
         ref_b[i] = seed_word(i);
      end
      for (int i = 0; i < 4; i++) begin
         rv[i] = 1'b0; rt[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #0.5;
      // R1 reset state
      check(!a_busy && !a_done && !b_busy && !b_done, "R1 busy/done low after reset",
            {a_busy, a_done, b_busy, b_done}, 0);
      check(!a_mrd && !a_mwr && !b_mrd && !b_mwr, "R1 strobes low after reset",
            {a_mrd, a_mwr, b_mrd, b_mwr}, 0);
      check(a_hits == 0 && a_miss == 0, "R1 counters zero after reset", {a_hits, a_miss}, 0);

      // R1/R3/R8: first access misses, same block hits, same index other tag evicts
      access(0, 8'h05, '0, 0, '0);
      access(0, 8'h06, '0, 0, '0);
      access(0, 8'h45, '0, 0, '0);
      access(0, 8'h05, '0, 0, '0);
      check(a_hits == 1 && a_miss == 3, "R8 index conflict eviction", {a_hits, a_miss}, {16'd1, 16'd3});

      // R4 write hit then read back from the line
      access(1, 8'h05, 32'hDEAD0001, 0, '0);
      access(0, 8'h05, '0, 0, '0);
      access(0, 8'h04, '0, 0, '0);

      // R5 write miss on index 1: no allocation
      mbase = a_miss;
      access(1, 8'h87, 32'hBEEF0002, 0, '0);
      access(0, 8'h05, '0, 0, '0);
      check(a_miss == mbase + 1, "R5 resident line kept after write miss", a_miss, mbase + 1);
      access(0, 8'h87, '0, 0, '0);
      check(a_miss == mbase + 2, "R5 written address not allocated", a_miss, mbase + 2);

      // R7 requests while busy are ignored
      access(0, 8'hC8, '0, 1, 8'h31);
      check(m0.store[6'h0C][32 +: 32] == ref_a[8'h31], "R7 write while busy ignored",
            m0.store[6'h0C][32 +: 32], ref_a[8'h31]);

      // random traffic on the cached instance
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] ra;
         ra = ($urandom_range(9, 0) == 0) ? AW'($urandom_range(255, 0)) : AW'($urandom_range(63, 0));
         access($urandom_range(2, 0) == 0, ra, $urandom, 0, '0);
      end

      // R9 bypass instance
      sel = 1'b1;
      access(0, 8'h12, '0, 0, '0);
      access(0, 8'h12, '0, 0, '0);
      access(1, 8'h12, 32'h0BB0_1234, 0, '0);
      access(0, 8'h12, '0, 0, '0);
      access(0, 8'h13, '0, 0, '0);
      for (int n = 0; n < 60; n++) begin
         access($urandom_range(1, 0) == 1, AW'($urandom_range(255, 0)), $urandom, 0, '0);
      end

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog R1-R9 run did not complete act=%0d exp=%0d", 0, 1);
         summary();
         $finish;
      end
   end
endmodule